// File: doc/BRIEF.md
# Dual Down-Counting Timer with Interrupt Aggregation

This block holds two independent down-counting timers behind a small 32-bit register window, with a shared set of interrupt registers: raw status, mask and masked status. Each timer has a divisor register that supplies its reload value and a control register. A write to the control register picks an operation (load, hold or run) and a tick source. A running timer counts down on its selected tick. When it expires it reloads from the divisor, so it repeats with a fixed period, and it sets a sticky raw interrupt bit. One interrupt output is high whenever raw status ANDed with the mask is nonzero.

Software clears status bits by writing ones to an acknowledge location. That location keeps no value. A free-running time register counts pulses of a separate tick input and cannot be written.

The tick inputs are single-cycle enables made by clock-domain logic outside the block. Four reference tick lines and one external tick line feed the source selector of each timer. Accesses are whole 32-bit words. Writes take effect on the clock edge where `wrEn` is high. Reads are combinational from `addr`.

Top module: `dual_timer_irq`

## Requirements
- R1: After reset both timers are stopped with count 0 and divisor 0, and the raw status, mask and time registers are 0. `irqOut` is low.
- R2: A control write (timer0 at 0x08, timer1 at 0x18) decodes the operation from bits [1:0]. Value 0 copies the divisor into the count, 1 stops the timer, 2 starts it, and 3 leaves the run state and the count unchanged. Every control write also captures the tick source from bits [4:2].
- R3: A stopped timer keeps its count whatever ticks arrive.
- R4: A running timer whose count is above 1 decrements by one on each selected tick. On a selected tick at count 0 or 1 it reloads from the divisor and sets its raw status bit: bit 0 for timer0, bit 1 for timer1. The period is therefore the divisor in ticks, and a divisor of 0 expires on every tick.
- R5: Tick source code 0 selects `extTick`. Codes 4 to 7 select `refTick[0]` to `refTick[3]`. Codes 1, 2 and 3 never tick.
- R6: The mask register at 0x48 holds bits [1:0], and its other bits read 0. The masked status at 0x54 reads raw AND mask. `irqOut` is high exactly when raw AND mask is nonzero, from the cycle after the write that changes it.
- R7: A write to 0x4C clears each raw status bit written as 1 and leaves the others. An expiry in the same cycle keeps its bit set. The acknowledge location reads 0.
- R8: A divisor write (timer0 at 0x00, timer1 at 0x10) does not change the count. The new value is used at the next load or reload.
- R9: In the cycle of a control write the timer does not count, even if its tick is present.
- R10: The time register at 0x38 increases by one for each cycle in which `timeTick` is high, and writes to it are ignored.
- R11: The counts read at 0x04 and 0x14 and the raw status reads at 0x50. Reads of divisor and control locations, of the acknowledge location and of any unmapped offset return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe for the word at `addr` |
| addr | input | 7 | Byte offset of the accessed word |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| refTick | input | 4 | Reference tick enables for source codes 4 to 7 |
| extTick | input | 1 | External tick enable for source code 0 |
| timeTick | input | 1 | Tick enable for the free-running time register |
| irqOut | output | 1 | Interrupt, high when masked status is nonzero |

## Verification
Directed sequences drive single tick pulses by hand, so that reload at expiry, a held count, a divisor change between loads and each source code can be told apart. The sequences also set up cases where an acknowledge or a control write lands in the same cycle as a tick, to separate "set wins" from "clear wins" and to show that a control write suppresses counting. A long phase then mixes random tick patterns on every line with random writes to all offsets. That phase reaches interleavings of expiry, mask and acknowledge that the directed cases do not. A behavioural model checks `irqOut` on every cycle and checks each read.

// File: rtl/dt_pkg.sv
package dt_pkg;

  localparam int DATA_W  = 32;
  localparam int NUM_TMR = 2;
  localparam int REF_BASE = 4;

  // register offsets (bytes)
  localparam int OFF_DIV0   = 'h00;
  localparam int OFF_CNT0   = 'h04;
  localparam int OFF_CTL0   = 'h08;
  localparam int OFF_DIV1   = 'h10;
  localparam int OFF_CNT1   = 'h14;
  localparam int OFF_CTL1   = 'h18;
  localparam int OFF_TIME   = 'h38;
  localparam int OFF_MASK   = 'h48;
  localparam int OFF_ACK    = 'h4C;
  localparam int OFF_RAW    = 'h50;
  localparam int OFF_MASKED = 'h54;

  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_HOLD = 2'd1,
    OP_RUN  = 2'd2,
    OP_NOP  = 2'd3
  } tmrOp_e;

  typedef enum logic [2:0] {
    RD_ZERO, RD_CNT0, RD_CNT1, RD_TIME, RD_MASK, RD_RAW, RD_MASKED
  } rdSel_e;

  typedef struct packed {
    logic [NUM_TMR-1:0] divWr;
    logic [NUM_TMR-1:0] ctlWr;
    logic               maskWr;
    logic               ackWr;
  } dtStrobes_t;

endpackage

// File: rtl/dt_ctrl.sv
module dt_ctrl
  import dt_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output dtStrobes_t        strb,
  output rdSel_e            rdSel
);

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int off);
    return a == ADDR_W'(off);
  endfunction

  always_comb begin
    strb  = '0;
    rdSel = RD_ZERO;
    if (hit(addr, OFF_DIV0))   strb.divWr[0] = wrEn;
    if (hit(addr, OFF_DIV1))   strb.divWr[1] = wrEn;
    if (hit(addr, OFF_CTL0))   strb.ctlWr[0] = wrEn;
    if (hit(addr, OFF_CTL1))   strb.ctlWr[1] = wrEn;
    if (hit(addr, OFF_MASK))   strb.maskWr   = wrEn;
    if (hit(addr, OFF_ACK))    strb.ackWr    = wrEn;
    if (hit(addr, OFF_CNT0))   rdSel = RD_CNT0;
    if (hit(addr, OFF_CNT1))   rdSel = RD_CNT1;
    if (hit(addr, OFF_TIME))   rdSel = RD_TIME;
    if (hit(addr, OFF_MASK))   rdSel = RD_MASK;
    if (hit(addr, OFF_RAW))    rdSel = RD_RAW;
    if (hit(addr, OFF_MASKED)) rdSel = RD_MASKED;
  end

endmodule

// File: rtl/dt_timer.sv
module dt_timer
  import dt_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int NUM_REF = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               divWr,
  input  logic               ctlWr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_REF-1:0] refTick,
  input  logic               extTick,
  output logic [CNT_W-1:0]   count,
  output logic               expire
);

  localparam int SRC_W = $clog2(REF_BASE + NUM_REF);

  logic [CNT_W-1:0] cntQ, divQ;
  logic [SRC_W-1:0] srcQ;
  logic             runQ;
  logic             tick;
  tmrOp_e           op;

  assign op = tmrOp_e'(wrData[1:0]);

  always_comb begin
    tick = 1'b0;
    if (srcQ == '0) tick = extTick;
    for (int k = 0; k < NUM_REF; k++)
      if (int'(srcQ) == REF_BASE + k) tick = refTick[k];
  end

  assign expire = runQ && tick && !ctlWr && (cntQ <= CNT_W'(1));
  assign count  = cntQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
      divQ <= '0;
      srcQ <= '0;
      runQ <= 1'b0;
    end else begin
      if (divWr) divQ <= wrData[CNT_W-1:0];
      if (ctlWr) begin
        srcQ <= wrData[2 +: SRC_W];
        case (op)
          OP_LOAD: cntQ <= divQ;
          OP_HOLD: runQ <= 1'b0;
          OP_RUN:  runQ <= 1'b1;
          default: ;
        endcase
      end else if (runQ && tick) begin
        cntQ <= (cntQ <= CNT_W'(1)) ? divQ : cntQ - CNT_W'(1);
      end
    end
  end

  // R3: stopped timer keeps its count
  assert_hold_frozen_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!runQ && !ctlWr) |=> $stable(cntQ));

  // R2: load operation copies divisor
  assert_load_copies_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWr && op == OP_LOAD) |=> (cntQ == $past(divQ)));

  // R5: no selected tick, no movement
  assert_no_tick_still_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !ctlWr) |=> $stable(cntQ));

  // R9: control write cycle never decrements
  assert_ctl_no_count_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWr && op != OP_LOAD) |=> $stable(cntQ));

endmodule

// File: rtl/dt_datapath.sv
module dt_datapath
  import dt_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int NUM_REF = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  dtStrobes_t         strb,
  input  rdSel_e             rdSel,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_REF-1:0] refTick,
  input  logic               extTick,
  input  logic               timeTick,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqOut
);

  logic [CNT_W-1:0]   cnt [NUM_TMR];
  logic [NUM_TMR-1:0] expire;
  logic [NUM_TMR-1:0] rawQ, maskQ, ackBits;
  logic [DATA_W-1:0]  timeQ;

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    dt_timer #(.CNT_W(CNT_W), .NUM_REF(NUM_REF)) u_tmr (
      .clk    (clk),
      .rstN   (rstN),
      .divWr  (strb.divWr[i]),
      .ctlWr  (strb.ctlWr[i]),
      .wrData (wrData),
      .refTick(refTick),
      .extTick(extTick),
      .count  (cnt[i]),
      .expire (expire[i])
    );

    // R4: expiry sets its raw bit
    assert_expire_sets_R4: assert property (@(posedge clk) disable iff (!rstN)
      expire[i] |=> rawQ[i]);

    // R7: written-one acknowledge clears unless an expiry coincides
    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
      (strb.ackWr && wrData[i] && !expire[i]) |=> !rawQ[i]);
  end

  assign ackBits = strb.ackWr ? wrData[NUM_TMR-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rawQ  <= '0;
      maskQ <= '0;
      timeQ <= '0;
    end else begin
      rawQ <= (rawQ & ~ackBits) | expire;
      if (strb.maskWr) maskQ <= wrData[NUM_TMR-1:0];
      if (timeTick) timeQ <= timeQ + DATA_W'(1);
    end
  end

  assign irqOut = |(rawQ & maskQ);

  always_comb begin
    case (rdSel)
      RD_CNT0:   rdData = DATA_W'(cnt[0]);
      RD_CNT1:   rdData = DATA_W'(cnt[1]);
      RD_TIME:   rdData = timeQ;
      RD_MASK:   rdData = DATA_W'(maskQ);
      RD_RAW:    rdData = DATA_W'(rawQ);
      RD_MASKED: rdData = DATA_W'(rawQ & maskQ);
      default:   rdData = '0;
    endcase
  end

  // R10: time register steps by exactly one per tick
  assert_time_step_R10: assert property (@(posedge clk) disable iff (!rstN)
    timeTick |=> (timeQ == $past(timeQ) + DATA_W'(1)));

  assert_time_still_R10: assert property (@(posedge clk) disable iff (!rstN)
    !timeTick |=> $stable(timeQ));

  // R6: mask write lands on the next edge
  assert_mask_load_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.maskWr |=> (maskQ == $past(wrData[NUM_TMR-1:0])));

endmodule

// File: rtl/dual_timer_irq.sv
module dual_timer_irq
  import dt_pkg::*;
#(
  parameter int ADDR_W  = 7,
  parameter int CNT_W   = 32,
  parameter int NUM_REF = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [31:0]        wrData,
  output logic [31:0]        rdData,
  input  logic [NUM_REF-1:0] refTick,
  input  logic               extTick,
  input  logic               timeTick,
  output logic               irqOut
);

  dtStrobes_t strb;
  rdSel_e     rdSel;

  dt_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrEn (wrEn),
    .addr (addr),
    .strb (strb),
    .rdSel(rdSel)
  );

  dt_datapath #(.CNT_W(CNT_W), .NUM_REF(NUM_REF)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .rdSel   (rdSel),
    .wrData  (wrData),
    .refTick (refTick),
    .extTick (extTick),
    .timeTick(timeTick),
    .rdData  (rdData),
    .irqOut  (irqOut)
  );

endmodule

// File: tb/dual_timer_irq_bench.sv
module dual_timer_irq_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [3:0]  refTick = '0;
  logic        extTick = 1'b0;
  logic        timeTick = 1'b0;
  logic        irqOut;

  int  nChk = 0, nFail = 0, cyc = 0;
  bit  tickOn = 1'b0, done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_timer_irq u_dual_timer_irq (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .refTick(refTick), .extTick(extTick),
    .timeTick(timeTick), .irqOut(irqOut)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] mCnt [2];
  logic [31:0] mDiv [2];
  bit          mRun [2];
  int          mSrc [2];
  logic [1:0]  mRaw, mMask;
  logic [31:0] mTime;

  function automatic bit srcTick(int s);
    if (s == 0) return extTick;
    if (s >= 4 && s <= 7) return refTick[s-4];
    return 1'b0;
  endfunction

  function automatic logic [31:0] mRead(logic [6:0] a);
    case (a)
      7'h04: return mCnt[0];
      7'h14: return mCnt[1];
      7'h38: return mTime;
      7'h48: return {30'd0, mMask};
      7'h50: return {30'd0, mRaw};
      7'h54: return {30'd0, mRaw & mMask};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin : model
    logic [1:0] setB;
    logic [1:0] clrB;
    if (!rstN) begin
      for (int t = 0; t < 2; t++) begin
        mCnt[t] = 0; mDiv[t] = 0; mRun[t] = 0; mSrc[t] = 0;
      end
      mRaw = 0; mMask = 0; mTime = 0;
    end else begin
      setB = 0;
      for (int t = 0; t < 2; t++) begin
        if (wrEn && addr == (t == 0 ? 7'h08 : 7'h18)) begin
          if (wrData[1:0] == 2'd0) mCnt[t] = mDiv[t];
          if (wrData[1:0] == 2'd1) mRun[t] = 0;
          if (wrData[1:0] == 2'd2) mRun[t] = 1;
          mSrc[t] = int'(wrData[4:2]);
        end else if (mRun[t] && srcTick(mSrc[t])) begin
          if (mCnt[t] <= 1) begin mCnt[t] = mDiv[t]; setB[t] = 1'b1; end
          else mCnt[t] = mCnt[t] - 1;
        end
      end
      if (wrEn && addr == 7'h00) mDiv[0] = wrData;
      if (wrEn && addr == 7'h10) mDiv[1] = wrData;
      clrB = (wrEn && addr == 7'h4C) ? wrData[1:0] : 2'b00;
      mRaw = (mRaw & ~clrB) | setB;
      if (wrEn && addr == 7'h48) mMask = wrData[1:0];
      if (timeTick) mTime = mTime + 1;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // R6: interrupt output compared with the model every cycle
  always @(negedge clk)
    if (rstN && !done) chk(irqOut === |(mRaw & mMask), "R6 irqOut", irqOut, |(mRaw & mMask));

  always @(negedge clk)
    if (tickOn) begin
      refTick  = 4'($urandom);
      extTick  = 1'($urandom);
      timeTick = 1'($urandom);
    end

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk); wrEn = 1; addr = a; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic rd(logic [6:0] a, string req);
    @(negedge clk); wrEn = 0; addr = a;
    #1 chk(rdData === mRead(a), req, rdData, mRead(a));
  endtask

  task automatic pulse(logic [3:0] r, bit e, bit tt);
    @(negedge clk); refTick = r; extTick = e; timeTick = tt;
    @(negedge clk); refTick = 0; extTick = 0; timeTick = 0;
  endtask

  // write and tick in the same cycle
  task automatic wrTick(logic [6:0] a, logic [31:0] d, logic [3:0] r);
    @(negedge clk); wrEn = 1; addr = a; wrData = d; refTick = r;
    @(negedge clk); wrEn = 0; refTick = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      nChk++; nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("[TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state
    chk(irqOut === 1'b0, "R1 irq after reset", irqOut, 0);
    rd(7'h04, "R1 count0"); chk(rdData === 0, "R1 count0 zero", rdData, 0);
    rd(7'h14, "R1 count1");
    rd(7'h50, "R1 raw");    chk(rdData === 0, "R1 raw zero", rdData, 0);
    rd(7'h48, "R1 mask");
    rd(7'h38, "R1 time");

    // R2 load, R8 divisor write keeps count
    wr(7'h00, 32'd3);
    wr(7'h08, (32'd4 << 2) | 32'd0);
    rd(7'h04, "R2 load"); chk(rdData === 32'd3, "R2 load value", rdData, 3);
    wr(7'h00, 32'd7);
    rd(7'h04, "R8 count unchanged"); chk(rdData === 32'd3, "R8 count kept", rdData, 3);
    // R11: write-only and unmapped read zero
    rd(7'h00, "R11 div reads 0");  rd(7'h08, "R11 ctl reads 0");
    rd(7'h4C, "R11 ack reads 0");  rd(7'h20, "R11 unmapped 0");
    rd(7'h58, "R11 past window 0");

    // R4 run on refTick[0] (code 4)
    wr(7'h08, (32'd4 << 2) | 32'd2);
    pulse(4'b0001, 0, 0); rd(7'h04, "R4 decrement");
    pulse(4'b0010, 0, 0); rd(7'h04, "R5 other ref ignored");
    pulse(4'b0001, 0, 0); rd(7'h04, "R4 count one");
    pulse(4'b0001, 0, 0); rd(7'h04, "R4 R8 reload new divisor");
    chk(rdData === 32'd7, "R4 reload value", rdData, 7);
    rd(7'h50, "R4 raw bit0"); chk(rdData === 32'd1, "R4 raw bit0 set", rdData, 1);
    chk(irqOut === 1'b0, "R6 masked off", irqOut, 0);

    // R6 mask
    wr(7'h48, 32'hFFFF_FFFF);
    rd(7'h48, "R6 mask bits"); rd(7'h54, "R6 masked");
    chk(irqOut === 1'b1, "R6 irq high", irqOut, 1);

    // R7 acknowledge
    wr(7'h4C, 32'd2); rd(7'h50, "R7 ack other bit keeps");
    wr(7'h4C, 32'd1); rd(7'h50, "R7 ack clears");
    chk(irqOut === 1'b0, "R7 irq low after ack", irqOut, 0);

    // R3 hold
    wr(7'h08, (32'd4 << 2) | 32'd1);
    pulse(4'b1111, 1, 0); pulse(4'b0001, 0, 0);
    rd(7'h04, "R3 held count"); chk(rdData === 32'd7, "R3 held value", rdData, 7);

    // R5 source codes on timer1
    wr(7'h10, 32'd2);
    wr(7'h18, (32'd1 << 2) | 32'd0);
    wr(7'h18, (32'd1 << 2) | 32'd2);
    pulse(4'b1111, 1, 0); rd(7'h14, "R5 code1 never ticks");
    wr(7'h18, (32'd3 << 2) | 32'd2);
    pulse(4'b1111, 1, 0); rd(7'h14, "R5 code3 never ticks");
    wr(7'h18, (32'd0 << 2) | 32'd2);
    pulse(4'b0000, 1, 0); rd(7'h14, "R5 code0 ext tick");
    wr(7'h18, (32'd7 << 2) | 32'd3);
    pulse(4'b1000, 0, 0); rd(7'h14, "R5 R2 code7 op3 keeps run");
    rd(7'h50, "R4 raw bit1");

    // R7 same-cycle expiry and ack: timer1 divisor 0, expires every tick
    wr(7'h10, 32'd0);
    wr(7'h18, (32'd7 << 2) | 32'd0);
    wr(7'h18, (32'd7 << 2) | 32'd2);
    wrTick(7'h4C, 32'd3, 4'b1000);
    rd(7'h50, "R7 expiry beats ack");
    chk(rdData[1] === 1'b1, "R7 bit1 kept", rdData, 2);

    // R9 control write with tick present
    wr(7'h00, 32'd5);
    wr(7'h08, (32'd4 << 2) | 32'd0);
    wrTick(7'h08, (32'd4 << 2) | 32'd2, 4'b0001);
    rd(7'h04, "R9 no count on ctl write");
    chk(rdData === 32'd5, "R9 value", rdData, 5);

    // R10 time register
    pulse(0, 0, 1); pulse(0, 0, 1);
    wr(7'h38, 32'h1234);
    rd(7'h38, "R10 time");
    chk(rdData === mTime, "R10 time two ticks", rdData, mTime);

    // random mix
    tickOn = 1;
    for (int i = 0; i < 3000; i++) begin
      int sel;
      sel = $urandom_range(0, 9);
      case (sel)
        0: wr(7'h00, $urandom_range(0, 12));
        1: wr(7'h10, $urandom_range(0, 12));
        2: wr(7'h08, {27'($urandom), 3'($urandom_range(0, 7)), 2'($urandom)});
        3: wr(7'h18, {27'($urandom), 3'($urandom_range(0, 7)), 2'($urandom)});
        4: wr(7'h48, $urandom);
        5: wr(7'h4C, $urandom);
        6: wr(7'($urandom_range(0, 22) * 4), $urandom);
        default: begin
          logic [6:0] ra;
          ra = 7'($urandom_range(0, 23) * 4);
          rd(ra, "R11 R4 random read");
        end
      endcase
    end
    tickOn = 0;
    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

endmodule